// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer of 512 words of 18 bits. The write port and the read port each have their own clock. Each port has an active-low enable, sampled on the rising edge of that port's clock. Each pointer is kept in binary for addressing and in gray code for crossing. The gray copy of each pointer passes to the other domain through a two-stage synchronizer. Each domain then compares its own pointer with the synchronized copy of the other.

The write domain derives full, half-full and almost-full. The read domain derives empty and almost-empty. The almost-full and almost-empty offsets are held in registers that reset to 63 words. A load strobe on the write clock can reprogram them to any value across the depth. The read domain receives the almost-empty offset through its own two-stage register.

An active-high retransmit input sends the read pointer back to physical address zero and leaves the write pointer alone. Every word from address zero up to the current write position can then be replayed as often as needed. This holds as long as neither pointer has wrapped past the end of the array since the last reset.

Top module: `rwnd_fifo`

## Requirements
- R1: Words leave in the order they were accepted, unmodified. Read data appears on `dout` after the rising `rclk` edge that accepts the read, and `dout` holds its value otherwise.
- R2: A write is accepted on a rising `wclk` edge only when `wen_n` is 0 and `full` is 0. A read is accepted on a rising `rclk` edge only when `ren_n` is 0, `empty` is 0 and `rt` is 0.
- R3: While `rst_n` is 0, both pointers clear. `empty` and `almost_empty` read 1. `full`, `almost_full` and `half_full` read 0. `dout` reads 0, and both offsets return to 63.
- R4: `full` is 1 exactly when 512 words are held, as seen by the write side. A write attempted while full is dropped, and the stored contents and order do not change.
- R5: A read attempted while empty is dropped: `dout` keeps its value and the next accepted read returns the next word written.
- R6: `half_full` is 1 when the write-side occupancy is at least 257 words.
- R7: `almost_full` is 1 when the write-side occupancy is at least 512 minus the almost-full offset. With the default offset, that is 449 words.
- R8: `almost_empty` is 1 when the read-side occupancy is at most the almost-empty offset (default 63 words). `empty` is 1 at zero occupancy, and `almost_empty` is 1 whenever `empty` is 1.
- R9: When `cfg_ld` is 1 on a rising `wclk` edge, `cfg_af_ofs` becomes the almost-full offset and `cfg_ae_ofs` becomes the almost-empty offset.
- R10: When `rt` is 1 on a rising `rclk` edge, the read pointer goes to address 0 and the write pointer is unchanged. The words from address 0 onward are then read again in order. `rt` takes priority over a read requested in the same cycle.
- R11: After a retransmit edge, `empty` and `almost_empty` reflect the rewound read pointer within two `rclk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous reset, active low, both domains |
| wen_n | input | 1 | Write enable, active low |
| din | input | 18 | Write data |
| cfg_ld | input | 1 | Offset load strobe, write clock domain |
| cfg_af_ofs | input | 9 | Almost-full offset value to load |
| cfg_ae_ofs | input | 9 | Almost-empty offset value to load |
| ren_n | input | 1 | Read enable, active low |
| rt | input | 1 | Retransmit, active high, read clock domain |
| dout | output | 18 | Read data |
| full | output | 1 | Buffer holds 512 words |
| almost_full | output | 1 | Occupancy within the almost-full offset of the top |
| half_full | output | 1 | Occupancy at least 257 words |
| almost_empty | output | 1 | Occupancy at most the almost-empty offset |
| empty | output | 1 | Buffer holds no words |

## Verification
The situation hardest to reach from the ports is a retransmit that lands on the same read edge as a pending read, after the buffer has already been drained to empty. At that point the flags must recover, and the replay must start again from word zero with nothing skipped.

The stimulus first resets the block so that no pointer has wrapped. It then writes and drains a short block, and raises retransmit and read enable together. It replays part of the block, rewinds a second time, and appends a new word. The scoreboard is rebuilt from the bench's own record of accepted writes, so it catches a skipped, repeated or lost word.

The full and near-full thresholds are reached by filling all 512 entries one write at a time. Every flag is checked after each write.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   // smallest synchronizer depth accepted for a pointer crossing
   localparam int unsigned SYNC_MIN = 2;

   // occupancy at which the half-full flag turns on
   function automatic int unsigned half_level(input int unsigned depth);
      return depth / 2 + 1;
   endfunction
endpackage

// File: rtl/rwf_sync.sv
module rwf_sync #(
   parameter int unsigned W       = 10,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < rwf_pkg::SYNC_MIN) begin : g_bad_depth
         initial $error("rwf_sync: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/rwf_mem.sv
module rwf_mem #(
   parameter int unsigned DW = 18,
   parameter int unsigned AW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned ENTRIES = 1 << AW;

   logic [DW-1:0] arr [ENTRIES];

   always_ff @(posedge wclk) begin
      if (we) arr[waddr] <= wdata;
   end

   // output register only moves on an accepted read
   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= arr[raddr];
   end
endmodule

// File: rtl/rwf_wside.sv
module rwf_wside #(
   parameter int unsigned AW       = 9,
   parameter int unsigned DEPTH    = 512,
   parameter int unsigned HALF_LVL = 257,
   parameter int unsigned OFS_DEF  = 63
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wen_n,
   input  logic          cfg_ld,
   input  logic [AW-1:0] cfg_af,
   input  logic [AW-1:0] cfg_ae,
   input  logic [AW:0]   rgray_s,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          almost_full,
   output logic          half_full,
   output logic [AW-1:0] ae_ofs
);
   localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
   localparam logic [AW:0]   HALF_C  = (AW+1)'(HALF_LVL);
   localparam logic [AW-1:0] OFS_C   = AW'(OFS_DEF);

   logic [AW:0]   wbin, wbin_nx, rbin_s, occ;
   logic [AW-1:0] af_ofs;

   // gray to binary for the read pointer seen in this domain
   always_comb begin
      rbin_s[AW] = rgray_s[AW];
      for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign occ         = wbin - rbin_s;
   assign full        = (occ == DEPTH_C);
   assign almost_full = (occ >= (DEPTH_C - {1'b0, af_ofs}));
   assign half_full   = (occ >= HALF_C);
   assign wr_fire     = !wen_n && !full;
   assign wbin_nx     = wbin + (AW+1)'(1);
   assign waddr       = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_fire) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         af_ofs <= OFS_C;
         ae_ofs <= OFS_C;
      end else if (cfg_ld) begin
         af_ofs <= cfg_af;
         ae_ofs <= cfg_ae;
      end
   end

   a_r4_occ_bound: assert property (@(posedge wclk) disable iff (!rst_n)
      occ <= DEPTH_C);
   a_r4_full_drops_write: assert property (@(posedge wclk) disable iff (!rst_n)
      (full && !wen_n) |=> $stable(wgray));
   a_r7_full_implies_upper_flags: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> (almost_full && half_full));
endmodule

// File: rtl/rwf_rside.sv
module rwf_rside #(
   parameter int unsigned AW          = 9,
   parameter int unsigned OFS_DEF     = 63,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          ren_n,
   input  logic          rt,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] ae_ofs_w,
   output logic          rd_fire,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          empty,
   output logic          almost_empty
);
   logic [AW:0]   rbin, rbin_nx, wbin_s, occ;
   logic [AW-1:0] ae_ofs;

   // offset is quasi-static; it is re-registered into this clock
   rwf_sync #(
      .W       (AW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (AW'(OFS_DEF))
   ) u_ae_sync (
      .clk   (rclk),
      .rst_n (rst_n),
      .din   (ae_ofs_w),
      .dout  (ae_ofs)
   );

   always_comb begin
      wbin_s[AW] = wgray_s[AW];
      for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign occ          = wbin_s - rbin;
   assign empty        = (occ == '0);
   assign almost_empty = (occ <= {1'b0, ae_ofs});
   assign rd_fire      = !ren_n && !empty && !rt;
   assign rbin_nx      = rbin + (AW+1)'(1);
   assign raddr        = rbin[AW-1:0];

   // rewind wins over a read requested on the same edge
   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rt) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_fire) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   a_r5_empty_drops_read: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty && !ren_n && !rt) |=> $stable(rgray));
   a_r10_rewind_to_zero: assert property (@(posedge rclk) disable iff (!rst_n)
      rt |=> (rgray == '0));
   a_r8_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |-> almost_empty);
endmodule

// File: rtl/rwnd_fifo.sv
module rwnd_fifo #(
   parameter int unsigned DATA_W      = 18,
   parameter int unsigned DEPTH       = 512,
   parameter int unsigned OFS_DEF     = 63,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned HALF_LVL   = rwf_pkg::half_level(DEPTH)
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wen_n,
   input  logic [DATA_W-1:0] din,
   input  logic              cfg_ld,
   input  logic [AW-1:0]     cfg_af_ofs,
   input  logic [AW-1:0]     cfg_ae_ofs,
   input  logic              ren_n,
   input  logic              rt,
   output logic [DATA_W-1:0] dout,
   output logic              full,
   output logic              almost_full,
   output logic              half_full,
   output logic              almost_empty,
   output logic              empty
);
   initial begin
      assert (DEPTH == (1 << AW)) else $error("rwnd_fifo: DEPTH must be a power of two");
      assert (OFS_DEF < DEPTH)    else $error("rwnd_fifo: OFS_DEF out of range");
   end

   logic          wr_fire, rd_fire;
   logic [AW-1:0] waddr, raddr, ae_ofs;
   logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

   rwf_wside #(
      .AW (AW), .DEPTH (DEPTH), .HALF_LVL (HALF_LVL), .OFS_DEF (OFS_DEF)
   ) u_wside (
      .wclk        (wclk),
      .rst_n       (rst_n),
      .wen_n       (wen_n),
      .cfg_ld      (cfg_ld),
      .cfg_af      (cfg_af_ofs),
      .cfg_ae      (cfg_ae_ofs),
      .rgray_s     (rgray_s),
      .wr_fire     (wr_fire),
      .waddr       (waddr),
      .wgray       (wgray),
      .full        (full),
      .almost_full (almost_full),
      .half_full   (half_full),
      .ae_ofs      (ae_ofs)
   );

   rwf_rside #(
      .AW (AW), .OFS_DEF (OFS_DEF), .SYNC_STAGES (SYNC_STAGES)
   ) u_rside (
      .rclk         (rclk),
      .rst_n        (rst_n),
      .ren_n        (ren_n),
      .rt           (rt),
      .wgray_s      (wgray_s),
      .ae_ofs_w     (ae_ofs),
      .rd_fire      (rd_fire),
      .raddr        (raddr),
      .rgray        (rgray),
      .empty        (empty),
      .almost_empty (almost_empty)
   );

   rwf_sync #(.W (AW + 1), .STAGES (SYNC_STAGES)) u_w2r (
      .clk (rclk), .rst_n (rst_n), .din (wgray), .dout (wgray_s)
   );

   rwf_sync #(.W (AW + 1), .STAGES (SYNC_STAGES)) u_r2w (
      .clk (wclk), .rst_n (rst_n), .din (rgray), .dout (rgray_s)
   );

   rwf_mem #(.DW (DATA_W), .AW (AW)) u_mem (
      .wclk  (wclk),
      .we    (wr_fire),
      .waddr (waddr),
      .wdata (din),
      .rclk  (rclk),
      .rst_n (rst_n),
      .re    (rd_fire),
      .raddr (raddr),
      .rdata (dout)
   );
endmodule

// File: tb/rwnd_fifo_tb_top.sv
module rwnd_fifo_tb_top;
   localparam int DW = 18, DEPTH = 512, AW = 9, DEF = 63;

   logic wclk = 0, rclk = 0, rst_n = 0;
   logic wen_n = 1, ren_n = 1, rt = 0, cfg_ld = 0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] cfg_af = '0, cfg_ae = '0;
   logic [DW-1:0] dout;
   logic full, almost_full, half_full, almost_empty, empty;

   int n_chk = 0, n_bad = 0;
   int wr_m = 0, rd_m = 0;
   bit pop_pend = 0;
   logic [DW-1:0] sb[$];
   logic [DW-1:0] hist[$];

   always #4 wclk = ~wclk;   // 125 MHz write clock
   always #5 rclk = ~rclk;

   rwnd_fifo dut_i (
      .wclk (wclk), .rclk (rclk), .rst_n (rst_n), .wen_n (wen_n), .din (din),
      .cfg_ld (cfg_ld), .cfg_af_ofs (cfg_af), .cfg_ae_ofs (cfg_ae),
      .ren_n (ren_n), .rt (rt), .dout (dout), .full (full),
      .almost_full (almost_full), .half_full (half_full),
      .almost_empty (almost_empty), .empty (empty)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // driver: one write attempt, expected item pushed when the model accepts it
   task automatic wr(input logic [DW-1:0] v);
      bit acc;
      acc = (wr_m - rd_m) < DEPTH;
      @(negedge wclk); wen_n = 0; din = v;
      @(negedge wclk); wen_n = 1;
      if (acc) begin sb.push_back(v); hist.push_back(v); wr_m++; end
   endtask

   task automatic rd();
      bit acc;
      acc = (wr_m - rd_m) > 0;
      @(negedge rclk); ren_n = 0;
      @(posedge rclk); #1;
      if (acc) begin pop_pend = 1; rd_m++; end
      @(negedge rclk); ren_n = 1;
   endtask

   task automatic settle();
      repeat (6) @(negedge rclk);
      repeat (2) @(negedge wclk);
   endtask

   task automatic do_reset();
      @(negedge wclk); rst_n = 0;
      repeat (3) @(negedge wclk);
      sb.delete(); hist.delete(); wr_m = 0; rd_m = 0; pop_pend = 0;
      rst_n = 1;
      settle();
   endtask

   // monitor: compare each accepted read against the scoreboard
   always @(negedge rclk) begin
      if (pop_pend) begin
         pop_pend = 0;
         if (sb.size() == 0) chk("R1 unexpected read data", 32'(dout), 32'h0dead);
         else chk("R1 R10 data order", 32'(dout), 32'(sb.pop_front()));
      end
   end

   initial begin
      #1_500_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] last;
      repeat (3) @(negedge wclk);
      rst_n = 1;
      settle();
      // R3 reset state
      chk("R3 empty", 32'(empty), 1);
      chk("R3 almost_empty", 32'(almost_empty), 1);
      chk("R3 full", 32'(full), 0);
      chk("R3 almost_full", 32'(almost_full), 0);
      chk("R3 half_full", 32'(half_full), 0);
      chk("R3 dout", 32'(dout), 0);

      // R1 R2 mixed traffic, two data patterns
      for (int i = 0; i < 8; i++) wr(18'h15555 ^ DW'(i * 37));
      settle();
      for (int i = 0; i < 3; i++) rd();
      for (int i = 0; i < 5; i++) wr(DW'(1) << (i % DW));
      settle();
      for (int i = 0; i < 10; i++) rd();
      settle();
      chk("R2 empty after balanced traffic", 32'(empty), 1);
      chk("R1 scoreboard drained", sb.size(), 0);

      // R4 R6 R7 fill with default offsets
      for (int k = 1; k <= DEPTH; k++) begin
         wr(DW'(k * 131) ^ 18'h2C3A5);
         chk("R4 full", 32'(full), 32'(k == DEPTH));
         chk("R7 almost_full", 32'(almost_full), 32'(k >= DEPTH - DEF));
         chk("R6 half_full", 32'(half_full), 32'(k >= 257));
      end
      wr(18'h3FFFF);
      chk("R4 full after dropped write", 32'(full), 1);
      settle();
      chk("R8 not empty when full", 32'(empty), 0);
      chk("R8 not almost_empty when full", 32'(almost_empty), 0);

      // R8 drain with default offset; R4 marker must never appear
      for (int rem = DEPTH - 1; rem >= 0; rem--) begin
         rd();
         chk("R8 almost_empty", 32'(almost_empty), 32'(rem <= DEF));
         chk("R8 empty", 32'(empty), 32'(rem == 0));
      end
      @(negedge rclk);
      chk("R4 no extra word after full", sb.size(), 0);

      // R5 read on empty is dropped
      last = dout;
      rd();
      @(negedge rclk);
      chk("R5 dout held on empty read", 32'(dout), 32'(last));
      chk("R5 still empty", 32'(empty), 1);
      wr(18'h2AAAA);
      settle();
      rd();
      @(negedge rclk);
      chk("R5 next word after empty read", sb.size(), 0);

      // R9 programmed offsets
      do_reset();
      @(negedge wclk); cfg_af = 9'd10; cfg_ae = 9'd5; cfg_ld = 1;
      @(negedge wclk); cfg_ld = 0;
      settle();
      for (int k = 1; k <= 6; k++) begin
         wr(DW'(k));
         settle();
         chk("R9 almost_empty programmed", 32'(almost_empty), 32'(k <= 5));
      end
      for (int k = 7; k <= 502; k++) begin
         wr(DW'(k));
         if (k >= 500) chk("R9 almost_full programmed", 32'(almost_full), 32'(k >= 502));
      end

      // R10 R11 retransmit with no pointer wrap since reset
      do_reset();
      for (int i = 0; i < 10; i++) wr(18'h30F00 + DW'(i));
      settle();
      for (int i = 0; i < 10; i++) rd();
      @(negedge rclk);
      chk("R10 empty before rewind", 32'(empty), 1);
      @(negedge rclk); rt = 1; ren_n = 0;   // read requested on the rewind edge
      @(negedge rclk); rt = 0; ren_n = 1;
      sb.delete();
      foreach (hist[j]) sb.push_back(hist[j]);
      rd_m = 0;
      @(negedge rclk);
      chk("R11 empty after rewind", 32'(empty), 0);
      chk("R11 almost_empty after rewind", 32'(almost_empty), 1);
      for (int i = 0; i < 4; i++) rd();
      @(negedge rclk); rt = 1;
      @(negedge rclk); rt = 0;
      sb.delete();
      foreach (hist[j]) sb.push_back(hist[j]);
      rd_m = 0;
      wr(18'h0BEEF);                         // write pointer continues past 10
      settle();
      for (int i = 0; i < 11; i++) rd();
      @(negedge rclk);
      chk("R10 replay complete", sb.size(), 0);
      chk("R11 empty after replay", 32'(empty), 1);

      summary();
      $finish;
   end
endmodule